// File: doc/BRIEF.md
# Flash Command Controller with Register Interface

This block puts a small byte-addressed register file in front of a flash array model built from on-chip registers. Software loads an opcode and a 24-bit byte address into one 32-bit command word and a longword into the data registers. It then starts the operation by writing one to the done flag in the status register. While the command runs, software polls the status register for completion, for the two error flags and for the verify result.

The array is organised as `NUM_SECTORS` sectors of `SECTOR_BYTES` bytes, held as 32-bit words. Erase and verify commands walk the affected words one per clock. A program command finishes in a single decode cycle. A per-sector protection mask input refuses erase and program requests to guarded sectors. A separate word-wide read port gives direct reads of the array contents. That port returns zero while a command is in flight and records the collision in the status register.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80, the command word and both data registers read zero, and every array word reads 0xFFFFFFFF on the read port.
- R2: Bus offset 0x4 holds the command word, with the opcode in bits 31:24 and the byte address in bits 23:0. Offset 0x8 holds data word 0 and offset 0xC holds data word 1. All three read back as written, but writes to them while the done flag (status bit 7) is low are dropped.
- R3: A status write with bit 7 set launches the loaded command only if, before that write, bit 7 is 1 and bits 5 and 4 are both 0. A launch drops bit 7 and clears bit 0 on the next cycle.
- R4: Writing 1 to status bit 5 (access error), bit 4 (protection error) or bit 6 (read collision) clears that bit. Writing 0 to any of them leaves it unchanged.
- R5: A launch write while bit 5 or bit 4 is set is ignored and bit 7 stays 1, even when the same write clears those bits.
- R6: Opcode 0x06 ANDs data word 0 into the word at a 4-byte-aligned address. Bit 7 is low for exactly 1 cycle.
- R7: Opcode 0x09 sets every word of the sector that holds the address to 0xFFFFFFFF and leaves other sectors alone. Bit 7 is low for 1 + SECTOR_BYTES/4 cycles.
- R8: Opcode 0x01 checks the addressed sector (1 + SECTOR_BYTES/4 low cycles) and opcode 0x40 checks the whole array (1 + total words low cycles). At completion, status bit 0 is 1 exactly when some checked word is not all ones.
- R9: Opcode 0x44 sets every word to all ones, with 1 + total words low cycles. If any protection mask bit is set, it instead sets bit 4 and changes nothing.
- R10: An unknown opcode, a program address with bits 1:0 not zero, or an address at or beyond the array size sets bit 5 when bit 7 rises one cycle after launch. The array is left unchanged.
- R11: A program or sector erase aimed at a sector whose `protMask` bit is 1 sets bit 4 and changes nothing. An access error takes precedence over a protection error.
- R12: With bit 7 high, the read port returns the word at `flashRdAddr`. A read while bit 7 is low returns zero and sets bit 6, and bit 6 does not block a launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register byte offset |
| busWr | input | 1 | Single-cycle write strobe |
| busRd | input | 1 | Read enable; busRdata is zero when low |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| flashRdEn | input | 1 | Array read request |
| flashRdAddr | input | log2(total words) | Array word index |
| flashRdData | output | 32 | Array word (combinational) |
| protMask | input | NUM_SECTORS | One bit per sector; 1 blocks erase and program |

## Verification
The assertions assume that only one register access is presented per cycle. They also assume that status writes which clear error flags arrive while bit 7 is high, because the flags are only raised on the cycle bit 7 rises. The stimulus keeps to this by issuing every register write through a single task and by waiting for completion before clearing flags, with the exception of the deliberate command-word write during a busy erase. The protection mask changes only while the controller is idle, because it is sampled one cycle after launch.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;
  localparam logic [7:0] OP_VERIFY_SEC = 8'h01;
  localparam logic [7:0] OP_PROG_WORD  = 8'h06;
  localparam logic [7:0] OP_ERASE_SEC  = 8'h09;
  localparam logic [7:0] OP_VERIFY_ALL = 8'h40;
  localparam logic [7:0] OP_ERASE_ALL  = 8'h44;

  localparam int unsigned STAT_DONE  = 7;
  localparam int unsigned STAT_RDCOL = 6;
  localparam int unsigned STAT_ACC   = 5;
  localparam int unsigned STAT_PROT  = 4;
  localparam int unsigned STAT_MISS  = 0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_ERASE,
    ST_VERIFY
  } fccState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cmdOpen;
    logic ptrLoad;
    logic ptrFromZero;
    logic ptrInc;
    logic eraseWr;
    logic progWr;
  } fccStrobe_t;
endpackage

// File: rtl/fcc_datapath.sv
`timescale 1ns/1ps
module fcc_datapath
  import fcc_pkg::*;
#(
  parameter int unsigned NUM_SECTORS  = 4,
  parameter int unsigned SECTOR_BYTES = 1024
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  fccStrobe_t                                  strb,
  input  logic [3:0]                                  busAddr,
  input  logic                                        busWr,
  input  logic                                        busRd,
  input  logic [31:0]                                 busWdata,
  output logic [31:0]                                 busRdata,
  input  logic [7:0]                                  statusByte,
  input  logic                                        ccif,
  input  logic [NUM_SECTORS-1:0]                      protMask,
  input  logic [$clog2(NUM_SECTORS*SECTOR_BYTES/4)-1:0] flashRdAddr,
  output logic [31:0]                                 flashRdData,
  output logic [7:0]                                  opcode,
  output logic                                        addrOk,
  output logic                                        wordAligned,
  output logic                                        secProt,
  output logic                                        anyProt,
  output logic                                        wordBlank,
  output logic                                        lastInSector,
  output logic                                        lastInArray
);
  localparam int unsigned WORD_CNT = NUM_SECTORS * SECTOR_BYTES / 4;
  localparam int unsigned WORD_AW  = $clog2(WORD_CNT);
  localparam int unsigned ARR_AW   = WORD_AW + 2;
  localparam int unsigned SB_AW    = $clog2(SECTOR_BYTES);
  localparam int unsigned SW_AW    = SB_AW - 2;
  localparam int unsigned SEC_AW   = $clog2(NUM_SECTORS);

  logic [31:0] cmdWord, dataLo, dataHi;
  logic [31:0] arr [WORD_CNT];
  logic [WORD_AW-1:0] ptr, wrIdx, cmdIdx;
  logic [SEC_AW-1:0]  secIdx;
  logic [31:0]        wrData;

  // command registers, writable only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord <= '0;
      dataLo  <= '0;
      dataHi  <= '0;
    end else if (busWr && strb.cmdOpen) begin
      case (busAddr)
        4'h4:    cmdWord <= busWdata;
        4'h8:    dataLo  <= busWdata;
        4'hC:    dataHi  <= busWdata;
        default: ;
      endcase
    end
  end

  assign opcode      = cmdWord[31:24];
  assign addrOk      = (cmdWord[23:ARR_AW] == '0);
  assign wordAligned = (cmdWord[1:0] == 2'b00);
  assign cmdIdx      = cmdWord[ARR_AW-1:2];
  assign secIdx      = cmdWord[ARR_AW-1:SB_AW];
  assign secProt     = protMask[secIdx];
  assign anyProt     = |protMask;

  // word walker for erase and verify
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ptr <= '0;
    else if (strb.ptrLoad)  ptr <= strb.ptrFromZero ? '0 : {secIdx, {SW_AW{1'b0}}};
    else if (strb.ptrInc)   ptr <= ptr + 1'b1;
  end

  assign lastInSector = &ptr[SW_AW-1:0];
  assign lastInArray  = &ptr;
  assign wordBlank    = &arr[ptr];

  // single write port into the array
  assign wrIdx  = strb.progWr ? cmdIdx : ptr;
  assign wrData = strb.progWr ? (arr[cmdIdx] & dataLo) : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORD_CNT; i++) arr[i] <= '1;
    end else if (strb.eraseWr || strb.progWr) begin
      arr[wrIdx] <= wrData;
    end
  end

  assign flashRdData = ccif ? arr[flashRdAddr] : '0;

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        4'h0:    busRdata = {24'h0, statusByte};
        4'h4:    busRdata = cmdWord;
        4'h8:    busRdata = dataLo;
        4'hC:    busRdata = dataHi;
        default: busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fcc_control.sv
`timescale 1ns/1ps
module fcc_control
  import fcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  busAddr,
  input  logic        busWr,
  input  logic [31:0] busWdata,
  input  logic        flashRdEn,
  input  logic [7:0]  opcode,
  input  logic        addrOk,
  input  logic        wordAligned,
  input  logic        secProt,
  input  logic        anyProt,
  input  logic        wordBlank,
  input  logic        lastInSector,
  input  logic        lastInArray,
  output fccStrobe_t  strb,
  output logic [7:0]  statusByte,
  output logic        ccif
);
  fccState_e state;
  logic allMode, accErr, protErr, rdColl, missFlag, verifyHit;
  logic statWr, launch, lastHit;
  logic decAcc, decProt, doProg, goErase, goVerify, goAll;

  assign statWr  = busWr && (busAddr == 4'h0);
  // judged on flag values before this write
  assign launch  = statWr && busWdata[STAT_DONE] && ccif && !accErr && !protErr;
  assign lastHit = allMode ? lastInArray : lastInSector;

  always_comb begin
    decAcc   = 1'b0;
    decProt  = 1'b0;
    doProg   = 1'b0;
    goErase  = 1'b0;
    goVerify = 1'b0;
    goAll    = 1'b0;
    case (opcode)
      OP_PROG_WORD: begin
        if (!addrOk || !wordAligned) decAcc  = 1'b1;
        else if (secProt)            decProt = 1'b1;
        else                         doProg  = 1'b1;
      end
      OP_ERASE_SEC: begin
        if (!addrOk)      decAcc  = 1'b1;
        else if (secProt) decProt = 1'b1;
        else              goErase = 1'b1;
      end
      OP_VERIFY_SEC: begin
        if (!addrOk) decAcc   = 1'b1;
        else         goVerify = 1'b1;
      end
      OP_VERIFY_ALL: begin
        goVerify = 1'b1;
        goAll    = 1'b1;
      end
      OP_ERASE_ALL: begin
        if (anyProt) decProt = 1'b1;
        else begin
          goErase = 1'b1;
          goAll   = 1'b1;
        end
      end
      default: decAcc = 1'b1;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.cmdOpen = ccif;
    case (state)
      ST_DECODE: begin
        strb.progWr      = doProg;
        strb.ptrLoad     = goErase || goVerify;
        strb.ptrFromZero = goAll;
      end
      ST_ERASE: begin
        strb.eraseWr = 1'b1;
        strb.ptrInc  = 1'b1;
      end
      ST_VERIFY: strb.ptrInc = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ccif      <= 1'b1;
      allMode   <= 1'b0;
      verifyHit <= 1'b0;
      missFlag  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          state     <= ST_DECODE;
          ccif      <= 1'b0;
          missFlag  <= 1'b0;
          verifyHit <= 1'b0;
        end
        ST_DECODE: begin
          allMode <= goAll;
          if (goErase)       state <= ST_ERASE;
          else if (goVerify) state <= ST_VERIFY;
          else begin
            state <= ST_IDLE;
            ccif  <= 1'b1;
          end
        end
        ST_ERASE: if (lastHit) begin
          state <= ST_IDLE;
          ccif  <= 1'b1;
        end
        ST_VERIFY: begin
          if (!wordBlank) verifyHit <= 1'b1;
          if (lastHit) begin
            state    <= ST_IDLE;
            ccif     <= 1'b1;
            missFlag <= verifyHit || !wordBlank;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // error flags: set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accErr  <= 1'b0;
      protErr <= 1'b0;
      rdColl  <= 1'b0;
    end else begin
      if (state == ST_DECODE && decAcc)         accErr <= 1'b1;
      else if (statWr && busWdata[STAT_ACC])    accErr <= 1'b0;
      if (state == ST_DECODE && decProt)        protErr <= 1'b1;
      else if (statWr && busWdata[STAT_PROT])   protErr <= 1'b0;
      if (flashRdEn && !ccif)                   rdColl <= 1'b1;
      else if (statWr && busWdata[STAT_RDCOL])  rdColl <= 1'b0;
    end
  end

  assign statusByte = {ccif, rdColl, accErr, protErr, 3'b000, missFlag};
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int unsigned NUM_SECTORS  = 4,
  parameter int unsigned SECTOR_BYTES = 1024
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic [3:0]                                    busAddr,
  input  logic                                          busWr,
  input  logic                                          busRd,
  input  logic [31:0]                                   busWdata,
  output logic [31:0]                                   busRdata,
  input  logic                                          flashRdEn,
  input  logic [$clog2(NUM_SECTORS*SECTOR_BYTES/4)-1:0] flashRdAddr,
  output logic [31:0]                                   flashRdData,
  input  logic [NUM_SECTORS-1:0]                        protMask
);
  fccStrobe_t strb;
  logic [7:0] statusByte, opcode;
  logic ccif, addrOk, wordAligned, secProt, anyProt, wordBlank, lastInSector, lastInArray;

  fcc_datapath #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECTOR_BYTES(SECTOR_BYTES)
  ) u_datapath (
    .clk, .rstN, .strb, .busAddr, .busWr, .busRd, .busWdata, .busRdata,
    .statusByte, .ccif, .protMask, .flashRdAddr, .flashRdData,
    .opcode, .addrOk, .wordAligned, .secProt, .anyProt, .wordBlank,
    .lastInSector, .lastInArray
  );

  fcc_control u_control (
    .clk, .rstN, .busAddr, .busWr, .busWdata, .flashRdEn,
    .opcode, .addrOk, .wordAligned, .secProt, .anyProt, .wordBlank,
    .lastInSector, .lastInArray, .strb, .statusByte, .ccif
  );
endmodule

// File: rtl/fcc_checker.sv
`timescale 1ns/1ps
module fcc_checker
  import fcc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  busAddr,
  input logic        busWr,
  input logic [31:0] busWdata,
  input logic        flashRdEn,
  input logic [7:0]  statusByte
);
  logic statWr;
  assign statWr = busWr && (busAddr == 4'h0);

  assert_launch_drops_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    statWr && busWdata[STAT_DONE] && statusByte[STAT_DONE] && !statusByte[STAT_ACC] && !statusByte[STAT_PROT]
    |=> !statusByte[STAT_DONE] && !statusByte[STAT_MISS]);

  assert_blocked_launch_R5: assert property (@(posedge clk) disable iff (!rstN)
    statWr && busWdata[STAT_DONE] && statusByte[STAT_DONE] && (statusByte[STAT_ACC] || statusByte[STAT_PROT])
    |=> statusByte[STAT_DONE]);

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    statWr && busWdata[STAT_ACC] && statusByte[STAT_DONE] |=> !statusByte[STAT_ACC]);

  assert_zero_write_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    statWr && !busWdata[STAT_PROT] && statusByte[STAT_PROT] && statusByte[STAT_DONE] |=> statusByte[STAT_PROT]);

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[STAT_ACC]) |-> $rose(statusByte[STAT_DONE]));

  assert_prot_with_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[STAT_PROT]) |-> $rose(statusByte[STAT_DONE]));

  assert_collision_flag_R12: assert property (@(posedge clk) disable iff (!rstN)
    flashRdEn && !statusByte[STAT_DONE] |=> statusByte[STAT_RDCOL]);
endmodule

bind flash_cmd_ctrl fcc_checker u_fcc_checker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWdata(busWdata), .flashRdEn(flashRdEn), .statusByte(statusByte)
);

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;
  localparam int unsigned NSEC  = 4;
  localparam int unsigned SECB  = 1024;
  localparam int unsigned WORDS = NSEC * SECB / 4;
  localparam int unsigned WPS   = SECB / 4;
  localparam int unsigned WAW   = $clog2(WORDS);
  localparam int unsigned ARR_BYTES = NSEC * SECB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b1;
  logic [31:0] busWdata = '0, busRdata;
  logic flashRdEn = 1'b0;
  logic [WAW-1:0] flashRdAddr = '0;
  logic [31:0] flashRdData;
  logic [NSEC-1:0] protMask = '0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.NUM_SECTORS(NSEC), .SECTOR_BYTES(SECB)) u_flash_cmd_ctrl (
    .clk, .rstN, .busAddr, .busWr, .busRd, .busWdata, .busRdata,
    .flashRdEn, .flashRdAddr, .flashRdData, .protMask
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mMem [WORDS];
  logic [31:0] mCmd, mD0, mD1;
  logic mDone, mRdc, mAcc, mProt, mMiss, pAcc, pProt, pMiss;
  logic preDone, preAcc, preProt;
  int mBusy, nLow, mSec, mBase;
  logic [7:0] mOp;
  logic [23:0] mAd;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mMem[i] = '1;
      mCmd = 0; mD0 = 0; mD1 = 0;
      mDone = 1; mRdc = 0; mAcc = 0; mProt = 0; mMiss = 0;
      pAcc = 0; pProt = 0; pMiss = 0; mBusy = 0;
    end else begin
      preDone = mDone; preAcc = mAcc; preProt = mProt;
      if (busWr && busAddr == 4'h0) begin
        if (busWdata[5]) mAcc = 0;
        if (busWdata[4]) mProt = 0;
        if (busWdata[6]) mRdc = 0;
      end
      if (flashRdEn && !preDone) mRdc = 1;
      if (!preDone) begin
        mBusy--;
        if (mBusy == 0) begin
          mDone = 1; mAcc = mAcc | pAcc; mProt = mProt | pProt; mMiss = pMiss;
        end
      end
      if (busWr && preDone) begin
        if (busAddr == 4'h4) mCmd = busWdata;
        if (busAddr == 4'h8) mD0 = busWdata;
        if (busAddr == 4'hC) mD1 = busWdata;
      end
      if (busWr && busAddr == 4'h0 && busWdata[7] && preDone && !preAcc && !preProt) begin
        mOp = mCmd[31:24]; mAd = mCmd[23:0];
        pAcc = 0; pProt = 0; pMiss = 0; nLow = 1;
        mSec = int'(mAd) / SECB; mBase = mSec * WPS;
        case (mOp)
          8'h06: if (mAd >= ARR_BYTES || mAd[1:0] != 0) pAcc = 1;
                 else if (protMask[mSec]) pProt = 1;
                 else mMem[mAd/4] = mMem[mAd/4] & mD0;
          8'h09: if (mAd >= ARR_BYTES) pAcc = 1;
                 else if (protMask[mSec]) pProt = 1;
                 else begin
                   for (int i = 0; i < WPS; i++) mMem[mBase+i] = '1;
                   nLow = 1 + WPS;
                 end
          8'h01: if (mAd >= ARR_BYTES) pAcc = 1;
                 else begin
                   for (int i = 0; i < WPS; i++) if (mMem[mBase+i] !== 32'hFFFFFFFF) pMiss = 1;
                   nLow = 1 + WPS;
                 end
          8'h40: begin
                   for (int i = 0; i < WORDS; i++) if (mMem[i] !== 32'hFFFFFFFF) pMiss = 1;
                   nLow = 1 + WORDS;
                 end
          8'h44: if (|protMask) pProt = 1;
                 else begin
                   for (int i = 0; i < WORDS; i++) mMem[i] = '1;
                   nLow = 1 + WORDS;
                 end
          default: pAcc = 1;
        endcase
        mDone = 0; mMiss = 0; mBusy = nLow;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && busRd && busAddr == 4'h0)
      chk("R3 status vs model", busRdata, {24'h0, mDone, mRdc, mAcc, mProt, 3'b000, mMiss});
    if (rstN && flashRdEn)
      chk("R12 read port vs model", flashRdData, mDone ? mMem[flashRdAddr] : 32'h0);
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWr = 1'b1; busWdata = d;
    @(negedge clk); busAddr = 4'h0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1; d = busRdata;
    @(negedge clk); busAddr = 4'h0;
  endtask

  task automatic flashRead(input int idx, output logic [31:0] d);
    @(negedge clk); flashRdEn = 1'b1; flashRdAddr = WAW'(idx); #1; d = flashRdData;
    @(negedge clk); flashRdEn = 1'b0;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    #1;
    while (!busRdata[7] && n < 5000) begin
      @(negedge clk); #1; n++;
    end
  endtask

  task automatic runCmd(input logic [7:0] op, input logic [23:0] ad, input logic [31:0] d0, output int n);
    regWrite(4'h8, d0);
    regWrite(4'h4, {op, ad});
    regWrite(4'h0, 32'h80);
    waitDone(n);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(4'h0, v); chk("R1 status", v, 32'h80);
    regRead(4'h4, v); chk("R1 cmd word", v, 0);
    regRead(4'h8, v); chk("R1 data0", v, 0);
    regRead(4'hC, v); chk("R1 data1", v, 0);
    flashRead(0, v); chk("R1 array first", v, 32'hFFFFFFFF);
    flashRead(WORDS-1, v); chk("R1 array last", v, 32'hFFFFFFFF);

    // R2 register readback
    regWrite(4'h4, 32'h06000010);
    regWrite(4'h8, 32'hA5A50F0F);
    regWrite(4'hC, 32'h11223344);
    regRead(4'h4, v); chk("R2 cmd readback", v, 32'h06000010);
    regRead(4'h8, v); chk("R2 data0 readback", v, 32'hA5A50F0F);
    regRead(4'hC, v); chk("R2 data1 readback", v, 32'h11223344);

    // R6 program
    regWrite(4'h0, 32'h80); waitDone(n);
    chk("R6 program busy cycles", n, 1);
    regRead(4'h0, v); chk("R6 status after program", v, 32'h80);
    flashRead(4, v); chk("R6 programmed word", v, 32'hA5A50F0F);
    runCmd(8'h06, 24'h000010, 32'hFFFF00FF, n);
    flashRead(4, v); chk("R6 AND into word", v, 32'hA5A5000F);

    // R8 sector verify
    runCmd(8'h01, 24'h000000, 0, n);
    chk("R8 verify sector cycles", n, 1 + WPS);
    regRead(4'h0, v); chk("R8 dirty sector flag", v, 32'h81);
    runCmd(8'h01, 24'h000400, 0, n);
    regRead(4'h0, v); chk("R8 clean sector flag (R3 clears bit0)", v, 32'h80);

    // R10 misaligned program
    runCmd(8'h06, 24'h000012, 32'h0, n);
    chk("R10 error busy cycles", n, 1);
    regRead(4'h0, v); chk("R10 misaligned access error", v, 32'hA0);
    flashRead(4, v); chk("R10 array unchanged", v, 32'hA5A5000F);

    // R5 blocked launch, R4 write-zero and clear
    regWrite(4'h0, 32'h80);
    regRead(4'h0, v); chk("R5 launch blocked by error", v, 32'hA0);
    regWrite(4'h0, 32'h00);
    regRead(4'h0, v); chk("R4 zero write keeps flag", v, 32'hA0);
    regWrite(4'h0, 32'hA0);
    regRead(4'h0, v); chk("R5 combined clear does not launch", v, 32'h80);

    // R10 unknown opcode and range
    runCmd(8'h45, 24'h000000, 0, n);
    regRead(4'h0, v); chk("R10 unknown opcode", v, 32'hA0);
    regWrite(4'h0, 32'h20);
    regRead(4'h0, v); chk("R4 one clears access error", v, 32'h80);
    runCmd(8'h06, 24'h001000, 0, n);
    regRead(4'h0, v); chk("R10 program out of range", v, 32'hA0);
    regWrite(4'h0, 32'h20);
    runCmd(8'h09, 24'h001000, 0, n);
    regRead(4'h0, v); chk("R10 erase out of range", v, 32'hA0);
    regWrite(4'h0, 32'h20);

    // R11 protection
    protMask = 4'b1000;
    runCmd(8'h06, 24'h000C00, 32'h0, n);
    regRead(4'h0, v); chk("R11 protected program", v, 32'h90);
    flashRead(12'h300, v); chk("R11 protected word unchanged", v, 32'hFFFFFFFF);
    regWrite(4'h0, 32'h10);
    regRead(4'h0, v); chk("R4 one clears protection error", v, 32'h80);
    runCmd(8'h09, 24'h000C04, 0, n);
    regRead(4'h0, v); chk("R11 protected erase", v, 32'h90);
    regWrite(4'h0, 32'h10);
    runCmd(8'h44, 24'h000000, 0, n);
    regRead(4'h0, v); chk("R9 erase-all refused under protection", v, 32'h90);
    flashRead(4, v); chk("R9 refused erase-all keeps data", v, 32'hA5A5000F);
    regWrite(4'h0, 32'h10);
    runCmd(8'h06, 24'h000C02, 0, n);
    regRead(4'h0, v); chk("R11 access error wins", v, 32'hA0);
    regWrite(4'h0, 32'h20);

    // R7 sector erase limited to its sector
    runCmd(8'h06, 24'h000404, 32'h0, n);
    flashRead(12'h101, v); chk("R7 setup word", v, 32'h0);
    runCmd(8'h09, 24'h0005FC, 0, n);
    chk("R7 erase sector cycles", n, 1 + WPS);
    flashRead(12'h101, v); chk("R7 sector erased", v, 32'hFFFFFFFF);
    flashRead(4, v); chk("R7 other sector untouched", v, 32'hA5A5000F);

    // R2 busy write dropped, R12 collision
    regWrite(4'h4, 32'h09000000);
    regWrite(4'h0, 32'h80);
    regWrite(4'h4, 32'h12345678);
    flashRead(0, v); chk("R12 busy read returns zero", v, 32'h0);
    waitDone(n);
    regRead(4'h4, v); chk("R2 busy write dropped", v, 32'h09000000);
    regRead(4'h0, v); chk("R12 collision flag", v, 32'hC0);
    flashRead(4, v); chk("R7 sector 0 erased", v, 32'hFFFFFFFF);
    runCmd(8'h01, 24'h000000, 0, n);
    regRead(4'h0, v); chk("R12 collision does not block", v, 32'hC0);
    regWrite(4'h0, 32'h40);
    regRead(4'h0, v); chk("R4 one clears collision", v, 32'h80);

    // R9 erase-all and R8 whole-array verify
    protMask = 4'b0000;
    runCmd(8'h06, 24'h000C00, 32'h0, n);
    runCmd(8'h40, 24'h000000, 0, n);
    chk("R8 verify all cycles", n, 1 + WORDS);
    regRead(4'h0, v); chk("R8 verify all dirty", v, 32'h81);
    runCmd(8'h44, 24'h000000, 0, n);
    chk("R9 erase all cycles", n, 1 + WORDS);
    regRead(4'h0, v); chk("R9 erase all status", v, 32'h80);
    flashRead(12'h300, v); chk("R9 array erased", v, 32'hFFFFFFFF);
    runCmd(8'h40, 24'h000000, 0, n);
    regRead(4'h0, v); chk("R8 verify all clean", v, 32'h80);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule